// File: doc/BRIEF.md
# Fractional Clock-Enable Divider

This block lets several instruction-executing engines run slower than the system clock. The system clock itself is never changed. For each channel the block raises a one-cycle step enable. Its average rate is the system clock frequency divided by a programmable 16.8 fixed-point divisor. Each of the four channels has its own divisor, so the engines can run at unrelated rates at the same time.

A divisor is loaded through a 32-bit register write port that selects a channel by address. The same value can be read back through a combinational read port. When the divisor has a fractional part, a phase accumulator spreads the leftover fraction over successive intervals. Each interval between enables is therefore one of two neighbouring lengths, and the long-run rate is exact. Writing a channel's divisor, or pulsing its restart input, puts that channel's phase back to zero.

Top module: `fcd_top`

## Requirements
- R1: In each channel's 32-bit register, bits [31:16] hold the integer part and bits [15:8] hold the fractional part. Bits [7:0] are dropped on a write and read back as zero. The value written is visible on the read port from the cycle after the write.
- R2: After reset every channel holds divisor 1.0, which reads back as 32'h0001_0000, and asserts its enable on every cycle.
- R3: With an integer divisor n and fractional part 0, a channel asserts its enable once every n cycles.
- R4: With a divisor of exactly 1.0, a channel asserts its enable on every cycle.
- R5: Count as cycle 1 the first cycle after the clock edge that samples a write or a restart. With D = n + f/256, the k-th enable after that edge falls in cycle floor(k*D). A divisor of 10.5 therefore gives 20 enables in the first 210 cycles.
- R6: Between two enables with no intervening write or restart, the gap is floor(D) or floor(D)+1 cycles.
- R7: An integer field of 0 selects a divisor of 65,536, and the fractional field is then ignored. After such a write exactly one enable occurs in the next 65,540 cycles.
- R8: A write to a channel's register clears that channel's phase. The next enable follows the timing of R5 under the new divisor.
- R9: A restart pulse on a channel clears its phase in the same way. A restart in the same cycle as a write to that channel has the same effect as the write alone.
- R10: A write or restart on one channel leaves the enable timing of every other channel unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Channel selected by a write |
| wr_data | input | 32 | Divisor value to write (16.8 in bits [31:8]) |
| rd_addr | input | ADDR_W | Channel selected for read-back |
| rd_data | output | 32 | Divisor of the selected channel, bits [7:0] zero |
| restart | input | NUM_CH | Per-channel phase restart |
| step_en | output | NUM_CH | Per-channel one-cycle step enable |

## Verification
The case that is hardest to reach from the ports is an integer field of zero. That divisor stands for 65,536, so it produces a single enable only after tens of thousands of cycles, and random stimulus that keeps writing and restarting never gets that far. A directed phase writes zero into the integer field with a non-zero fraction and then holds that channel untouched for more than one full interval. The other channels keep running during this phase. The random phase mixes writes, restarts, and writes that coincide with restarts. A per-cycle model of the floor(k*D) schedule predicts every enable, and it also checks that every gap is one of the two allowed lengths.

// File: rtl/fcd_pkg.sv
package fcd_pkg;
    localparam int INT_W    = 16;
    localparam int FRAC_W   = 8;
    localparam int CNT_W    = INT_W + 1;
    localparam int REG_W    = 32;
    localparam int INT_LSB  = 16;
    localparam int FRAC_LSB = 8;

    typedef struct packed {
        logic [CNT_W-1:0]  cnt;
        logic [FRAC_W-1:0] acc;
    } phase_t;
endpackage

// File: rtl/fcd_regbank.sv
module fcd_regbank
    import fcd_pkg::*;
#(
    parameter int NUM_CH = 4,
    parameter int ADDR_W = 2
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           wr_en,
    input  logic [ADDR_W-1:0]              wr_addr,
    input  logic [REG_W-1:0]               wr_data,
    input  logic [ADDR_W-1:0]              rd_addr,
    output logic [REG_W-1:0]               rd_data,
    output logic [NUM_CH-1:0][INT_W-1:0]   int_o,
    output logic [NUM_CH-1:0][FRAC_W-1:0]  frac_o,
    output logic [NUM_CH-1:0]              hit_o
);
    typedef struct packed {
        logic [NUM_CH-1:0][INT_W-1:0]  ival;
        logic [NUM_CH-1:0][FRAC_W-1:0] fval;
    } bank_t;

    bank_t bank_d, bank_q;
    logic  unused_low;

    assign unused_low = ^wr_data[FRAC_LSB-1:0];

    always_comb begin
        bank_d = bank_q;
        hit_o  = '0;
        for (int c = 0; c < NUM_CH; c++) begin
            if (wr_en && (wr_addr == ADDR_W'(c))) begin
                hit_o[c]       = 1'b1;
                bank_d.ival[c] = wr_data[INT_LSB +: INT_W];
                bank_d.fval[c] = wr_data[FRAC_LSB +: FRAC_W];
            end
        end
    end

    always_comb begin
        rd_data = '0;
        for (int c = 0; c < NUM_CH; c++) begin
            if (rd_addr == ADDR_W'(c)) begin
                rd_data = {bank_q.ival[c], bank_q.fval[c], {FRAC_LSB{1'b0}}};
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int c = 0; c < NUM_CH; c++) begin
                bank_q.ival[c] <= INT_W'(1);
                bank_q.fval[c] <= '0;
            end
        end else begin
            bank_q <= bank_d;
        end
    end

    assign int_o  = bank_q.ival;
    assign frac_o = bank_q.fval;

    // R1
    wr_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (int'(wr_addr) < NUM_CH)) |=>
            ((bank_q.ival[$past(wr_addr)] == $past(wr_data[INT_LSB +: INT_W])) &&
             (bank_q.fval[$past(wr_addr)] == $past(wr_data[FRAC_LSB +: FRAC_W]))));
endmodule

// File: rtl/fcd_channel.sv
module fcd_channel
    import fcd_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr_i,
    input  logic [INT_W-1:0]  int_i,
    input  logic [FRAC_W-1:0] frac_i,
    output logic              en_o
);
    phase_t            st_d, st_q;
    logic [CNT_W-1:0]  int_eff;
    logic [FRAC_W-1:0] frac_eff;
    logic [FRAC_W:0]   sum_c;
    logic [CNT_W-1:0]  len_c;
    logic              hit_c;

    always_comb begin
        if (int_i == '0) begin
            int_eff  = CNT_W'(1) << INT_W;
            frac_eff = '0;
        end else begin
            int_eff  = CNT_W'(int_i);
            frac_eff = frac_i;
        end
        sum_c = {1'b0, st_q.acc} + {1'b0, frac_eff};
        len_c = int_eff + CNT_W'(sum_c[FRAC_W]);
        hit_c = (st_q.cnt >= len_c);

        st_d = st_q;
        if (clr_i) begin
            st_d.cnt = CNT_W'(1);
            st_d.acc = '0;
        end else if (hit_c) begin
            st_d.cnt = CNT_W'(1);
            st_d.acc = sum_c[FRAC_W-1:0];
        end else begin
            st_d.cnt = st_q.cnt + CNT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.cnt <= CNT_W'(1);
            st_q.acc <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign en_o = hit_c;

    // R6
    cnt_in_interval_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.cnt != '0) && (st_q.cnt <= len_c));

    // R4
    unit_div_full_rate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((int_i == INT_W'(1)) && (frac_i == '0)) |-> en_o);

    // R9
    clr_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> (en_o == (int_i == INT_W'(1))));

    // R7
    zero_int_no_frac_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (int_i == '0) |-> (st_q.acc == '0));
endmodule

// File: rtl/fcd_top.sv
module fcd_top
    import fcd_pkg::*;
#(
    parameter  int NUM_CH = 4,
    localparam int ADDR_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [REG_W-1:0]  wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [REG_W-1:0]  rd_data,
    input  logic [NUM_CH-1:0] restart,
    output logic [NUM_CH-1:0] step_en
);
    logic [NUM_CH-1:0][INT_W-1:0]  int_w;
    logic [NUM_CH-1:0][FRAC_W-1:0] frac_w;
    logic [NUM_CH-1:0]             hit_w;
    logic [NUM_CH-1:0]             clr_w;

    fcd_regbank #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) u_bank (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (wr_en),
        .wr_addr(wr_addr),
        .wr_data(wr_data),
        .rd_addr(rd_addr),
        .rd_data(rd_data),
        .int_o  (int_w),
        .frac_o (frac_w),
        .hit_o  (hit_w)
    );

    assign clr_w = restart | hit_w;

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        fcd_channel u_ch (
            .clk   (clk),
            .rst_n (rst_n),
            .clr_i (clr_w[c]),
            .int_i (int_w[c]),
            .frac_i(frac_w[c]),
            .en_o  (step_en[c])
        );
    end

    // R10
    one_write_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(hit_w) && (!wr_en -> (hit_w == '0)));
endmodule

// File: tb/sim_fcd_top.sv
`timescale 1ns/1ps
module sim_fcd_top;
    localparam int NCH = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [1:0]  rd_addr = '0;
    logic [NCH-1:0] restart = '0;
    logic [31:0] rd_data;
    logic [NCH-1:0] step_en;

    always #2.5 clk = ~clk;

    fcd_top #(.NUM_CH(NCH)) u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .restart(restart), .step_en(step_en)
    );

    int     total = 0;
    int     bad = 0;
    bit     finished = 0;
    longint dv[NCH];
    longint m[NCH];
    longint k[NCH];
    longint last_m[NCH];
    int     en_cnt[NCH];
    string  cur_req;

    function automatic longint eff_div(logic [31:0] v);
        if (v[31:16] == 16'd0) return longint'(65536) * 256;
        return longint'(v[31:16]) * 256 + longint'(v[15:8]);
    endfunction

    function automatic bit exp_en(int c);
        return m[c] == (k[c] * dv[c]) / 256;
    endfunction

    task automatic check(string tag, longint act, longint exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s t=%0t act=%0d exp=%0d", tag, $time, act, exp);
        end
    endtask

    task automatic clear_counts();
        for (int c = 0; c < NCH; c++) en_cnt[c] = 0;
    endtask

    // Called just after a falling edge: check, drive, advance model, wait.
    task automatic clk_cycle(bit we, int wa, logic [31:0] wd, logic [NCH-1:0] rs);
        for (int c = 0; c < NCH; c++) begin
            bit e;
            e = exp_en(c);
            check(cur_req, longint'(step_en[c]), longint'(e));
            if (step_en[c]) en_cnt[c]++;
            if (e) begin
                if (k[c] > 1) begin
                    longint g;
                    g = m[c] - last_m[c];
                    check("R6", longint'((g == dv[c] / 256) || (g == dv[c] / 256 + 1)), 1);
                end
                last_m[c] = m[c];
                k[c]++;
            end
        end
        wr_en   = we;
        wr_addr = wa[1:0];
        wr_data = wd;
        restart = rs;
        for (int c = 0; c < NCH; c++) begin
            if (rs[c] || (we && wa == c)) begin
                if (we && wa == c) dv[c] = eff_div(wd);
                m[c] = 1;
                k[c] = 1;
            end else begin
                m[c]++;
            end
        end
        @(negedge clk);
        wr_en   = 1'b0;
        restart = '0;
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) clk_cycle(1'b0, 0, 32'd0, '0);
    endtask

    task automatic read_chk(int a, logic [31:0] exp, string tag);
        rd_addr = a[1:0];
        #0.5;
        check(tag, longint'(rd_data), longint'(exp));
    endtask

    initial begin
        void'($urandom(32'd7321));
        for (int c = 0; c < NCH; c++) begin
            dv[c] = 256; m[c] = 1; k[c] = 1; last_m[c] = 0; en_cnt[c] = 0;
        end
        cur_req = "R2";
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        for (int a = 0; a < NCH; a++) read_chk(a, 32'h0001_0000, "R2");
        idle(20);

        // R1 R3 R4 R5: directed divisors, ch0 written last to open the window
        cur_req = "R1";
        clk_cycle(1'b1, 1, 32'h0003_00C3, '0);
        clk_cycle(1'b1, 2, 32'h0001_0000, '0);
        clk_cycle(1'b1, 3, 32'h0007_4000, '0);
        clk_cycle(1'b1, 0, 32'h000A_80FF, '0);
        read_chk(0, 32'h000A_8000, "R1");
        read_chk(1, 32'h0003_0000, "R1");
        read_chk(3, 32'h0007_4000, "R1");
        clear_counts();
        cur_req = "R5";
        idle(210);
        check("R5", en_cnt[0], 20);
        check("R3", en_cnt[1], 70);
        check("R4", en_cnt[2], 210);

        // R8: rewrite mid-run
        cur_req = "R8";
        clk_cycle(1'b1, 1, 32'h0005_0000, '0);
        clear_counts();
        idle(4);
        check("R8", en_cnt[1], 0);
        idle(1);
        check("R8", en_cnt[1], 1);
        idle(20);

        // R9: restarts, and restart coinciding with a write
        cur_req = "R9";
        clk_cycle(1'b0, 0, 32'd0, 4'b1000);
        idle(30);
        clk_cycle(1'b0, 0, 32'd0, 4'b0001);
        idle(2);
        clk_cycle(1'b0, 0, 32'd0, 4'b0001);
        idle(15);
        clk_cycle(1'b1, 3, 32'h0002_8000, 4'b1000);
        idle(20);

        // R10: hammer ch0 while the others run
        cur_req = "R10";
        for (int i = 0; i < 20; i++) begin
            clk_cycle(1'b0, 0, 32'd0, 4'b0001);
            idle(2);
        end

        // R6: constrained random mix
        cur_req = "R6";
        for (int i = 0; i < 4000; i++) begin
            bit          we;
            int          wa;
            logic [31:0] wd;
            logic [NCH-1:0] rs;
            we = ($urandom % 40) == 0;
            wa = int'($urandom % NCH);
            wd = {16'(1 + $urandom % 24), 8'($urandom), 8'($urandom)};
            if (($urandom % 8) == 0) wd[15:8] = 8'd0;
            for (int c = 0; c < NCH; c++) rs[c] = ($urandom % 60) == 0;
            clk_cycle(we, wa, wd, rs);
        end

        // R7: integer field zero means 65536, fraction ignored
        cur_req = "R7";
        clk_cycle(1'b1, 2, 32'h0000_55AB, '0);
        read_chk(2, 32'h0000_5500, "R1");
        clear_counts();
        idle(65540);
        check("R7", en_cnt[2], 1);

        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog req=all act=running exp=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule